// File: doc/BRIEF.md
# Two-Channel Pulse-Width D/A Register Block

This block holds the registers and the compare logic of a two-channel pulse-width D/A converter that hangs off an 8-bit processor bus. A single 14-bit up-counter, advanced by a prescaled tick, is the time base for both channels. Each channel has a 16-bit data word: a 14-bit duty value, a carrier-select flag, and one further bit. Each channel drives one output bit that is high while the counter sits below the channel's duty value. A channel can compare at full 14-bit resolution, or at 12-bit resolution, in which case only the low twelve counter bits are used.

The four byte addresses form two 16-bit slots. A bank-select bit lets each slot show one of two registers. In one bank the slots hold data word A and data word B. In the other bank they hold the control word and the counter. The bank-select bit is always bit 0 of the byte at address 3, so software can always reach it. The bus is only 8 bits wide, so every 16-bit transfer goes through one shared staging byte. This keeps the two halves of a word coherent. The bus has no back-pressure: every read or write completes in the cycle it is presented, and read data is valid in that same cycle.

Top module: `pwm_dac_regs`

## Requirements
- R1: After reset, the bank-select bit is 1. The control word reads 0x1FFF, the counter word reads 0x0003, data word A reads 0xFFFF, and data word B holds all ones in bits 15..1.
- R2: The slot is chosen by address bit 1: addresses 0/1 give the high/low bytes of slot 0, and addresses 2/3 give the high/low bytes of slot 1. With the bank-select bit at 0, slot 0 is data word A and slot 1 is data word B. With the bank-select bit at 1, slot 0 is the control word and slot 1 is the counter.
- R3: A write to address 3 sets the bank-select bit from write-data bit 0 in either bank. The bank-select bit reads back as bit 0 of both data word B and the counter word.
- R4: A write to an even address only loads the staging byte. The following write to the odd address of the same slot commits {staging byte, written byte} to that slot's register in one cycle.
- R5: A read of an even address returns the register's high byte and captures its low byte into the staging byte. A read of the odd address returns the staging byte, even if the register has changed since the capture.
- R6: Some bits always read as 1: counter-word bit 1, data-word-A bit 0, and control-word bits 12..0. Only bits 15 (enable), 14 (channel A 14-bit mode) and 13 (channel B 14-bit mode) of the control word are stored.
- R7: While enabled, the counter (counter-word bits 15..2) increments by one on each cycle with the tick high. It wraps from 0x3FFF to 0. A committed counter write takes priority over the tick.
- R8: While the enable bit is 0, the counter is held at 0 and counter writes are ignored.
- R9: A channel in 14-bit mode drives its output high exactly when the counter is below the 14-bit duty value (data-word bits 15..2).
- R10: A channel in 12-bit mode drives its output high exactly when the counter's low 12 bits are below the top 12 bits of its duty value (data-word bits 15..4). The upper two counter bits have no effect.
- R11: Both outputs are low while the enable bit is 0.
- R12: While the stop input is high, every register, the counter, the staging byte and the bank-select bit return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Module-stop / low-power request, restores reset state |
| tick_i | input | 1 | Prescaled counter advance strobe |
| bus_addr | input | 2 | Byte address within the block |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the cycle of bus_rd |
| pwm_out | output | 2 | Channel outputs, bit 0 channel A, bit 1 channel B |

## Verification
The bench drives the duty compare right at the threshold: one count below the duty value and exactly at it. A compare written with <= instead of < shows up there as a one-count duty error. In 12-bit mode it picks counter values whose upper two bits would flip the result if they were compared, so a design that ignores the width setting disagrees. It lets the counter tick between the high-byte and low-byte reads, and a design that reads the low byte live then returns the new count instead of the captured one. It also toggles the bank-select bit through data word B and through the counter slot, and checks the wrap from 0x3FFF. A wrong bank decode or a missing always-one bit shows up as a wrong read byte.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = WORD_W - 2;
  localparam int N_CH   = 2;

  // slot index = {address bit 1, bank select}
  typedef enum logic [1:0] {
    SLOT_DATA_A = 2'd0,
    SLOT_CTRL   = 2'd1,
    SLOT_DATA_B = 2'd2,
    SLOT_COUNT  = 2'd3
  } slot_e;

  localparam logic [BYTE_W-1:0] STAGE_RST = '1;
endpackage

// File: rtl/pwm_dac_timebase.sv
module pwm_dac_timebase
  import pwm_dac_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         en,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (stop)   cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R8
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load && !stop) |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_dac_bridge.sv
module pwm_dac_bridge
  import pwm_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] view,
  output logic [BYTE_W-1:0] rdata,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word
);
  logic [BYTE_W-1:0] stage_q;
  logic              hi_byte;

  assign hi_byte = !addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             stage_q <= STAGE_RST;
    else if (stop)          stage_q <= STAGE_RST;
    else if (wr && hi_byte) stage_q <= wdata;
    else if (rd && hi_byte) stage_q <= view[BYTE_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd) rdata = hi_byte ? view[WORD_W-1:BYTE_W] : stage_q;
  end

  assign commit      = wr && !hi_byte;
  assign commit_word = {stage_q, wdata};

  // R5
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hi_byte && !wr && !stop) |=> stage_q == $past(view[BYTE_W-1:0]));

  // R4
  hi_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hi_byte && !stop) |=> commit_word[WORD_W-1:BYTE_W] == $past(wdata));
endmodule

// File: rtl/pwm_dac_channel.sv
module pwm_dac_channel
  import pwm_dac_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int NARROW_W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wide,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         pwm
);
  localparam int DROP = W - NARROW_W;

  logic [NARROW_W-1:0] cnt_n;
  logic [NARROW_W-1:0] duty_n;
  logic                below_w;
  logic                below_n;

  assign cnt_n   = cnt[NARROW_W-1:0];
  assign duty_n  = duty[W-1:DROP];
  assign below_w = cnt < duty;
  assign below_n = cnt_n < duty_n;
  assign pwm     = en && (wide ? below_w : below_n);

  // R11
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);
endmodule

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs
  import pwm_dac_pkg::*;
#(
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   pwm_out
);
  localparam int FILL_W = WORD_W - 3;

  logic              bank_q;
  logic              en_q;
  logic [N_CH-1:0]   wide_q;
  logic [WORD_W-1:1] data_q [N_CH];
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] view;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  slot_e             slot;
  logic              cnt_load;

  assign slot     = slot_e'({bus_addr[1], bank_q});
  assign cnt_load = commit && (slot == SLOT_COUNT);

  always_comb begin
    case (slot)
      SLOT_DATA_A: view = {data_q[0], 1'b1};
      SLOT_CTRL:   view = {en_q, wide_q[0], wide_q[1], {FILL_W{1'b1}}};
      SLOT_DATA_B: view = {data_q[1], bank_q};
      default:     view = {cnt, 1'b1, bank_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b1;
      en_q   <= 1'b0;
      wide_q <= '0;
      for (int i = 0; i < N_CH; i++) data_q[i] <= '1;
    end else if (stop_i) begin
      bank_q <= 1'b1;
      en_q   <= 1'b0;
      wide_q <= '0;
      for (int i = 0; i < N_CH; i++) data_q[i] <= '1;
    end else if (commit) begin
      if (bus_addr[1]) bank_q <= commit_word[0];
      case (slot)
        SLOT_DATA_A: data_q[0] <= commit_word[WORD_W-1:1];
        SLOT_DATA_B: data_q[1] <= commit_word[WORD_W-1:1];
        SLOT_CTRL: begin
          en_q      <= commit_word[WORD_W-1];
          wide_q[0] <= commit_word[WORD_W-2];
          wide_q[1] <= commit_word[WORD_W-3];
        end
        default: ;
      endcase
    end
  end

  pwm_dac_bridge u_bridge (
    .clk(clk), .rst_n(rst_n), .stop(stop_i), .addr(bus_addr),
    .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .view(view),
    .rdata(bus_rdata), .commit(commit), .commit_word(commit_word)
  );

  pwm_dac_timebase #(.W(CNT_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .stop(stop_i), .en(en_q), .tick(tick_i),
    .load(cnt_load), .load_val(commit_word[WORD_W-1:2]), .cnt(cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_dac_channel #(.W(CNT_W), .NARROW_W(NARROW_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en_q), .wide(wide_q[c]), .cnt(cnt),
      .duty(data_q[c][WORD_W-1:2]), .pwm(pwm_out[c])
    );
  end

  // R12
  stop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (bank_q && !en_q && data_q[0] == '1 && data_q[1] == '1));

  // R3
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && !stop_i) |=> bank_q == $past(bus_wdata[0]));
endmodule

// File: tb/tb_pwm_dac_regs.sv
module tb_pwm_dac_regs;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] pwm_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_NS/2) clk = ~clk;

  pwm_dac_regs dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .tick_i(tick_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design produces them
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 16'(bus_rdata), 16'hxxxx);
      else check(tag_q.pop_front(), 16'(bus_rdata), 16'(exp_q.pop_front()));
    end
  end

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr_word(input logic [1:0] slot_hi, input logic [15:0] w);
    wr_byte(slot_hi, w[15:8]);
    wr_byte(slot_hi | 2'd1, w[7:0]);
  endtask

  task automatic rd_byte(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_word(input logic [1:0] slot_hi, input logic [15:0] e, input string tag);
    rd_byte(slot_hi, e[15:8], tag);
    rd_byte(slot_hi | 2'd1, e[7:0], tag);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1; tick_i = 1'b1;
    repeat (n) @(posedge clk);
    #1; tick_i = 1'b0;
  endtask

  task automatic load_cnt(input logic [13:0] c);
    wr_word(2'd2, {c, 2'b11});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset view in bank 1 (control, counter)
    check("R11 outputs low after reset", 16'(pwm_out), 16'h0);
    rd_word(2'd0, 16'h1FFF, "R1 ctrl reset");
    rd_word(2'd2, 16'h0003, "R1 counter reset");
    // R3 bank select cleared through counter slot
    wr_word(2'd2, 16'h0000);
    rd_word(2'd0, 16'hFFFF, "R1 R6 data A reset");
    rd_word(2'd2, 16'hFFFE, "R2 R3 data B with bank bit 0");
    // R4 data writes
    wr_word(2'd0, 16'h1234);
    wr_word(2'd2, 16'hABCC);
    rd_word(2'd0, 16'h1235, "R4 R6 data A commit");
    rd_word(2'd2, 16'hABCC, "R4 data B commit");
    // R3 bank select set through data B low byte
    wr_word(2'd2, 16'hABCD);
    rd_word(2'd2, 16'h0003, "R2 R3 counter visible, R8 held while disabled");
    // enable, both 14-bit
    wr_word(2'd0, 16'hE000);
    rd_word(2'd0, 16'hFFFF, "R6 ctrl readback");
    load_cnt(14'h0100);
    rd_word(2'd2, 16'h0403, "R7 counter load");
    check("R9 A below duty", 16'(pwm_out), 16'h3);
    load_cnt(14'h048C);
    check("R9 A one below threshold", 16'(pwm_out), 16'h3);
    load_cnt(14'h048D);
    check("R9 A at threshold", 16'(pwm_out), 16'h2);
    load_cnt(14'h2AF3);
    check("R9 B at threshold", 16'(pwm_out), 16'h0);
    // R10 12-bit mode
    wr_word(2'd0, 16'h8000);
    load_cnt(14'h2122);
    check("R10 narrow ignores upper bits", 16'(pwm_out), 16'h3);
    load_cnt(14'h0123);
    check("R10 narrow at threshold", 16'(pwm_out), 16'h2);
    // R7 wrap
    wr_word(2'd0, 16'hE000);
    load_cnt(14'h3FFE);
    ticks(2);
    rd_word(2'd2, 16'h0003, "R7 wrap to zero");
    ticks(1);
    rd_word(2'd2, 16'h0007, "R7 single tick");
    // R5 coherent read across a tick
    load_cnt(14'h0005);
    rd_byte(2'd2, 8'h00, "R5 high byte");
    ticks(1);
    rd_byte(2'd3, 8'h17, "R5 low byte from capture");
    rd_word(2'd2, 16'h001B, "R5 fresh read");
    // R8 R11 disable
    wr_word(2'd0, 16'h6000);
    check("R11 outputs low disabled", 16'(pwm_out), 16'h0);
    rd_word(2'd0, 16'h7FFF, "R6 ctrl with enable clear");
    rd_word(2'd2, 16'h0003, "R8 counter cleared");
    ticks(3);
    load_cnt(14'h0777);
    rd_word(2'd2, 16'h0003, "R8 counter held and load ignored");
    // R12 stop
    wr_word(2'd2, 16'h0000);
    @(posedge clk); #1 stop_i = 1'b1;
    @(posedge clk); #1 stop_i = 1'b0;
    rd_word(2'd0, 16'h1FFF, "R12 ctrl restored, bank bit 1");
    rd_word(2'd2, 16'h0003, "R12 counter restored");
    wr_word(2'd2, 16'hFFFE);
    rd_word(2'd0, 16'hFFFF, "R12 data A restored");
    rd_word(2'd2, 16'hFFFE, "R12 data B restored");
    repeat (2) @(posedge clk);
    check("scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule